// File: doc/BRIEF.md
# Bus-Mapped Down-Counting Timer Bank

This block is a bank of independent 32-bit down-counters behind an APB slave port. Each timer has a small register window: a reload value, a live count, a three-bit control field, a clear-on-read acknowledge register and a masked status register. A shared page reports the masked and raw interrupt state of all timers, clears all of them in one read, and returns a fixed version word. Every counter runs on the bus clock.

When a timer is enabled it loads a start value and counts down by one per clock. A timer in periodic mode restarts from its reload register after it passes zero. A timer in free-running mode restarts from all ones instead, so software can read the inverted count as a rising time base. Each time a timer passes zero it sets a sticky raw interrupt bit. The timer's interrupt line shows that bit unless the timer's mask bit is set. Software acknowledges an interrupt by reading a register, not by writing one.

Each timer is driven by a two-state machine. T_OFF holds the count. T_RUN counts down. The transitions are START (T_OFF to T_RUN on the clock edge that sees enable at 1; the counter loads its start value), STOP (T_RUN to T_OFF on an edge that sees enable at 0; the count is frozen), and WRAP (a T_RUN self-loop on an edge where the count is zero; the counter reloads and the raw bit is set).

Top module: `apb_tmr_bank`

## Requirements
- R1: Timer n owns the window at byte address n*0x14. The offsets are: reload +0x00 (read/write, 32 bits), live count +0x04, control +0x08, acknowledge +0x0C and status +0x10. Control bit 0 is enable, bit 1 is periodic (1) or free-running (0), and bit 2 is the mask (1 masks the interrupt). The other control bits read as zero.
- R2: On each clock edge in T_RUN where the count is not zero, the count decreases by one. The live-count register returns the present count.
- R3: On each clock edge in T_RUN where the count is zero, the count reloads. A periodic timer reloads from its reload register. A free-running timer reloads with 0xFFFF_FFFF.
- R4: An enabled timer in T_OFF loads the value of R3 on the next edge and enters T_RUN, so a periodic reload value L gives a period of L+1 clocks. A disabled timer holds its count. A reload written while the timer is disabled is used only from the next start.
- R5: Interrupt output n and bit 0 of timer n's status register are both 1 exactly when the raw bit is 1 and the mask bit is 0.
- R6: The raw bit of a timer is set on every WRAP edge and stays set until it is cleared. The raw state of timer n is bit n at 0xA8.
- R7: An access-phase read of timer n's acknowledge register clears only that timer's raw bit and returns zero.
- R8: An access-phase read at 0xA4 clears every timer's raw bit and returns zero. If a timer wraps on the same edge, its raw bit stays set.
- R9: The masked interrupt state of timer n is bit n at 0xA0.
- R10: Unmapped addresses read as zero and ignore writes. pready is always 1 and pslverr is always 0.
- R11: 0xAC returns the VERSION parameter and ignores writes.
- R12: Reset clears every reload, control, count and raw bit, and puts every timer in T_OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counting clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data (combinational from the address) |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq | output | NUM_TMR | Masked interrupt line per timer |

## Verification
A register write lands on the clock edge of its access phase. The enable takes effect one edge later, when the count loads, and the count then moves by one per edge. Raw and interrupt bits change on the same edge as the wrap or the clearing read. Read data depends combinationally on state registered at the previous edge.

The bench keeps a reference model of every timer that advances on each rising edge from the bus traffic it drives itself. It compares read data a quarter period into the access phase, and the interrupt lines and bus response at every falling edge, so each result is checked in the first cycle it is due. Back-to-back acknowledge reads against a period-4 timer make some clears land on a wrap edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [0:0] {
        T_OFF = 1'b0,
        T_RUN = 1'b1
    } tmr_state_e;

    // Per-timer window stride and offsets (byte addresses)
    localparam int TMR_STRIDE = 20;
    localparam int OFS_LOAD   = 0;
    localparam int OFS_CUR    = 4;
    localparam int OFS_CTL    = 8;
    localparam int OFS_ACK    = 12;
    localparam int OFS_STS    = 16;

    // Shared page
    localparam int SH_STAT = 160;
    localparam int SH_ACK  = 164;
    localparam int SH_RAW  = 168;
    localparam int SH_VER  = 172;

    // Control field bit positions
    localparam int CTL_EN  = 0;
    localparam int CTL_PER = 1;
    localparam int CTL_MSK = 2;
    localparam int CTL_W   = 3;

endpackage

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              periodic,
    input  logic [DATA_W-1:0] load,
    input  logic              clr,
    output logic [DATA_W-1:0] cnt_o,
    output logic              raw_o
);

    tmr_state_e        state_q, state_d;
    logic [DATA_W-1:0] cnt_q, cnt_d;
    logic [DATA_W-1:0] reload;
    logic              wrap;
    logic              raw_q;

    assign reload = periodic ? load : {DATA_W{1'b1}};
    assign wrap   = (state_q == T_RUN) && en && (cnt_q == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_OFF;
        else        state_q <= state_d;
    end

    // START / STOP / WRAP
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            T_OFF: begin
                if (en) begin
                    state_d = T_RUN;
                    cnt_d   = reload;
                end
            end
            T_RUN: begin
                if (!en)                state_d = T_OFF;
                else if (cnt_q == '0)   cnt_d   = reload;
                else                    cnt_d   = cnt_q - DATA_W'(1);
            end
            default: state_d = T_OFF;
        endcase
    end

    // Outputs: count and sticky raw bit (set wins over clear)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            raw_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (wrap)     raw_q <= 1'b1;
            else if (clr) raw_q <= 1'b0;
        end
    end

    assign cnt_o = cnt_q;
    assign raw_o = raw_q;

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int                 NUM_TMR = 2,
    parameter int                 DATA_W  = 32,
    parameter int                 ADDR_W  = 8,
    parameter logic [DATA_W-1:0]  VERSION = 32'h0001_0200
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           psel,
    input  logic                           penable,
    input  logic                           pwrite,
    input  logic [ADDR_W-1:0]              paddr,
    input  logic [DATA_W-1:0]              pwdata,
    output logic [DATA_W-1:0]              prdata,
    output logic [NUM_TMR-1:0]             en_o,
    output logic [NUM_TMR-1:0]             per_o,
    output logic [NUM_TMR-1:0]             msk_o,
    output logic [NUM_TMR-1:0][DATA_W-1:0] load_o,
    output logic [NUM_TMR-1:0]             clr_o,
    input  logic [NUM_TMR-1:0][DATA_W-1:0] cnt_i,
    input  logic [NUM_TMR-1:0]             raw_i
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(SH_STAT);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(SH_ACK);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(SH_RAW);
    localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(SH_VER);

    logic wr_acc, rd_acc;
    logic [NUM_TMR-1:0] s_load, s_cur, s_ctl, s_ack, s_sts;
    logic [NUM_TMR-1:0][CTL_W-1:0]  ctl_q;
    logic [NUM_TMR-1:0][DATA_W-1:0] load_q;
    logic [NUM_TMR-1:0] masked;

    assign wr_acc = psel && penable && pwrite;
    assign rd_acc = psel && penable && !pwrite;

    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
        localparam logic [ADDR_W-1:0] B_LOAD = ADDR_W'(gi*TMR_STRIDE + OFS_LOAD);
        localparam logic [ADDR_W-1:0] B_CUR  = ADDR_W'(gi*TMR_STRIDE + OFS_CUR);
        localparam logic [ADDR_W-1:0] B_CTL  = ADDR_W'(gi*TMR_STRIDE + OFS_CTL);
        localparam logic [ADDR_W-1:0] B_ACK  = ADDR_W'(gi*TMR_STRIDE + OFS_ACK);
        localparam logic [ADDR_W-1:0] B_STS  = ADDR_W'(gi*TMR_STRIDE + OFS_STS);

        assign s_load[gi] = (paddr == B_LOAD);
        assign s_cur[gi]  = (paddr == B_CUR);
        assign s_ctl[gi]  = (paddr == B_CTL);
        assign s_ack[gi]  = (paddr == B_ACK);
        assign s_sts[gi]  = (paddr == B_STS);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_q[gi]  <= '0;
                load_q[gi] <= '0;
            end else if (wr_acc) begin
                if (s_ctl[gi])  ctl_q[gi]  <= pwdata[CTL_W-1:0];
                if (s_load[gi]) load_q[gi] <= pwdata;
            end
        end

        assign en_o[gi]   = ctl_q[gi][CTL_EN];
        assign per_o[gi]  = ctl_q[gi][CTL_PER];
        assign msk_o[gi]  = ctl_q[gi][CTL_MSK];
        assign load_o[gi] = load_q[gi];
        assign masked[gi] = raw_i[gi] && !ctl_q[gi][CTL_MSK];
        assign clr_o[gi]  = rd_acc && (s_ack[gi] || (paddr == A_ACK));
    end

    always_comb begin
        prdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (s_load[i]) prdata = load_q[i];
            if (s_cur[i])  prdata = cnt_i[i];
            if (s_ctl[i])  prdata = DATA_W'(ctl_q[i]);
            if (s_sts[i])  prdata = DATA_W'(masked[i]);
        end
        if (paddr == A_STAT) prdata = DATA_W'(masked);
        if (paddr == A_RAW)  prdata = DATA_W'(raw_i);
        if (paddr == A_VER)  prdata = VERSION;
    end

endmodule

// File: rtl/apb_tmr_bank.sv
module apb_tmr_bank
    import tmr_pkg::*;
#(
    parameter int                NUM_TMR = 2,
    parameter int                DATA_W  = 32,
    parameter int                ADDR_W  = 8,
    parameter logic [DATA_W-1:0] VERSION = 32'h0001_0200
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    output logic [DATA_W-1:0]  prdata,
    output logic               pready,
    output logic               pslverr,
    output logic [NUM_TMR-1:0] irq
);

    logic [NUM_TMR-1:0]             en_v, per_v, msk_v, clr_v, raw_v;
    logic [NUM_TMR-1:0][DATA_W-1:0] load_v, cnt_v;

    tmr_regif #(
        .NUM_TMR(NUM_TMR), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VERSION(VERSION)
    ) u_regif (
        .clk(pclk), .rst_n(presetn),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .en_o(en_v), .per_o(per_v), .msk_o(msk_v), .load_o(load_v),
        .clr_o(clr_v), .cnt_i(cnt_v), .raw_i(raw_v)
    );

    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_unit
        tmr_unit #(.DATA_W(DATA_W)) u_unit (
            .clk(pclk), .rst_n(presetn),
            .en(en_v[gi]), .periodic(per_v[gi]), .load(load_v[gi]),
            .clr(clr_v[gi]), .cnt_o(cnt_v[gi]), .raw_o(raw_v[gi])
        );
    end

    assign irq     = raw_v & ~msk_v;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int NUM_TMR = 2,
    parameter int DATA_W  = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           pready,
    input logic                           pslverr,
    input logic [NUM_TMR-1:0]             en,
    input logic [NUM_TMR-1:0]             per,
    input logic [NUM_TMR-1:0][DATA_W-1:0] load,
    input logic [NUM_TMR-1:0][DATA_W-1:0] cnt,
    input logic [NUM_TMR-1:0]             raw,
    input logic [NUM_TMR-1:0]             clr
);

    p_bus_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);

    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_t
        p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !en[gi] |=> $stable(cnt[gi]));

        p_start_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (en[gi] && !$past(en[gi])) |=>
            (cnt[gi] == ($past(per[gi]) ? $past(load[gi]) : {DATA_W{1'b1}})));

        p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (en[gi] && $past(en[gi]) && cnt[gi] != '0) |=>
            (cnt[gi] == $past(cnt[gi]) - DATA_W'(1)));

        p_wrap_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (en[gi] && $past(en[gi]) && cnt[gi] == '0) |=>
            (cnt[gi] == ($past(per[gi]) ? $past(load[gi]) : {DATA_W{1'b1}})));

        p_wrap_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (en[gi] && $past(en[gi]) && cnt[gi] == '0) |=> raw[gi]);

        p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[gi] && !(en[gi] && $past(en[gi]) && cnt[gi] == '0)) |=> !raw[gi]);
    end

endmodule

bind apb_tmr_bank tmr_chk #(.NUM_TMR(NUM_TMR), .DATA_W(DATA_W)) u_chk (
    .clk(pclk), .rst_n(presetn), .pready(pready), .pslverr(pslverr),
    .en(en_v), .per(per_v), .load(load_v), .cnt(cnt_v), .raw(raw_v), .clr(clr_v)
);

// File: tb/test_apb_tmr_bank.sv
module test_apb_tmr_bank;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 2;
    localparam int DW  = 32;
    localparam int AW  = 8;
    localparam logic [DW-1:0] VER = 32'h0001_0200;

    logic          pclk = 1'b0;
    logic          presetn = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic          pready, pslverr;
    logic [N-1:0]  irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    apb_tmr_bank #(.NUM_TMR(N), .DATA_W(DW), .ADDR_W(AW), .VERSION(VER)) i_apb_tmr_bank (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq(irq)
    );

    always #(CLK_PERIOD/2) pclk = ~pclk;

    // Reference model, advanced from the bench's own bus traffic
    logic [2:0]  m_ctl  [N];
    logic [31:0] m_load [N];
    logic [31:0] m_cnt  [N];
    bit          m_raw  [N];
    bit          m_run  [N];

    always @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            for (int i = 0; i < N; i++) begin
                m_ctl[i] = '0; m_load[i] = '0; m_cnt[i] = '0;
                m_raw[i] = 0;  m_run[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                automatic bit acc = psel && penable;
                automatic bit wr  = acc && pwrite;
                automatic bit rd  = acc && !pwrite;
                automatic int base = i*20;
                automatic bit en  = m_ctl[i][0];
                automatic logic [31:0] rel = m_ctl[i][1] ? m_load[i] : 32'hFFFF_FFFF;
                automatic bit wrap = m_run[i] && en && (m_cnt[i] == 0);
                automatic bit clr  = rd && (int'(paddr) == base+12 || int'(paddr) == 164);
                if (!en) m_run[i] = 0;
                else if (!m_run[i]) begin m_cnt[i] = rel; m_run[i] = 1; end
                else if (m_cnt[i] == 0) m_cnt[i] = rel;
                else m_cnt[i] = m_cnt[i] - 1;
                if (wrap) m_raw[i] = 1;
                else if (clr) m_raw[i] = 0;
                if (wr && int'(paddr) == base)   m_load[i] = pwdata;
                if (wr && int'(paddr) == base+8) m_ctl[i]  = pwdata[2:0];
            end
        end
    end

    function automatic bit masked_of(int i);
        return m_raw[i] && !m_ctl[i][2];
    endfunction

    function automatic logic [31:0] exp_read(logic [AW-1:0] a);
        automatic int ad = int'(a);
        for (int i = 0; i < N; i++) begin
            if (ad == i*20)      return m_load[i];
            if (ad == i*20 + 4)  return m_cnt[i];
            if (ad == i*20 + 8)  return {29'd0, m_ctl[i]};
            if (ad == i*20 + 16) return {31'd0, masked_of(i)};
        end
        if (ad == 160) begin
            automatic logic [31:0] v = '0;
            for (int i = 0; i < N; i++) v[i] = masked_of(i);
            return v;
        end
        if (ad == 168) begin
            automatic logic [31:0] v = '0;
            for (int i = 0; i < N; i++) v[i] = m_raw[i];
            return v;
        end
        if (ad == 172) return VER;
        return '0;
    endfunction

    function automatic string tag_of(logic [AW-1:0] a);
        automatic int ad = int'(a);
        for (int i = 0; i < N; i++) begin
            if (ad == i*20 || ad == i*20 + 8) return "R1";
            if (ad == i*20 + 4)  return "R2";
            if (ad == i*20 + 12) return "R7";
            if (ad == i*20 + 16) return "R5";
        end
        if (ad == 160) return "R9";
        if (ad == 164) return "R8";
        if (ad == 168) return "R6";
        if (ad == 172) return "R11";
        return "R10";
    endfunction

    function automatic logic [AW-1:0] pick_addr(int k);
        if (k < N*5) return AW'((k/5)*20 + (k%5)*4);
        case (k - N*5)
            0: return 8'hA0;
            1: return 8'hA4;
            2: return 8'hA8;
            3: return 8'hAC;
            4: return AW'(N*20);
            default: return 8'hB4;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apb_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1;
    endtask

    task automatic apb_read(logic [AW-1:0] a, string tag);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk);
        penable = 1;
        #(CLK_PERIOD/4);
        check(tag, prdata, exp_read(a));
    endtask

    task automatic bus_idle(int n);
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
        repeat (n) @(negedge pclk);
    endtask

    // Interrupt lines (R5) and bus response (R10) every cycle
    always @(negedge pclk) begin
        if (presetn && !done) begin
            automatic logic [31:0] e = '0;
            for (int i = 0; i < N; i++) e[i] = masked_of(i);
            check("R5", 32'(irq), e);
            check("R10", {30'd0, pready, pslverr}, 32'd2);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge pclk);
        presetn = 1;

        // R12: reset state of every register
        for (int k = 0; k < N*5 + 6; k++) apb_read(pick_addr(k), "R12");
        bus_idle(1);

        // R1 R2 R3 R4: periodic timer 0, reload 5
        apb_write(8'h00, 32'd5);
        apb_write(8'h08, 32'd3);
        apb_read(8'h04, "R4");
        for (int k = 0; k < 6; k++) apb_read(8'h04, "R2");
        apb_read(8'h10, "R5");
        apb_read(8'hA8, "R6");
        apb_read(8'hA0, "R9");
        apb_read(8'h0C, "R7");
        apb_read(8'h10, "R7");
        bus_idle(4);

        // R4: disable holds, new reload only on next start
        apb_write(8'h08, 32'd2);
        bus_idle(3);
        apb_read(8'h04, "R4");
        apb_write(8'h00, 32'd9);
        apb_read(8'h04, "R4");
        apb_write(8'h08, 32'd3);
        for (int k = 0; k < 4; k++) apb_read(8'h04, "R4");

        // R3: free-running timer 1 starts from all ones
        apb_write(8'h1C, 32'd1);
        for (int k = 0; k < 3; k++) apb_read(8'h18, "R3");

        // R5 R9: masked timer 0
        apb_write(8'h08, 32'd7);
        bus_idle(12);
        apb_read(8'hA8, "R6");
        apb_read(8'hA0, "R9");
        apb_read(8'h10, "R5");

        // R8: combined clear racing wraps (period 4 and 2)
        apb_write(8'h00, 32'd3);
        apb_write(8'h14, 32'd1);
        apb_write(8'h08, 32'd2);
        apb_write(8'h1C, 32'd2);
        apb_write(8'h08, 32'd3);
        apb_write(8'h1C, 32'd3);
        for (int k = 0; k < 24; k++) begin
            apb_read(8'hA4, "R8");
            apb_read(8'hA8, "R8");
        end
        apb_read(8'h0C, "R7");
        apb_read(8'hA8, "R7");

        // R10 R11: unmapped and read-only writes ignored
        apb_write(AW'(N*20), 32'hFFFF_FFFF);
        apb_write(8'h9C, 32'h1234_5678);
        apb_write(8'hB0, 32'hFFFF_FFFF);
        apb_write(8'h01, 32'hFFFF_FFFF);
        apb_write(8'hAC, 32'h0);
        apb_read(AW'(N*20), "R10");
        apb_read(8'hB0, "R10");
        apb_read(8'h01, "R10");
        apb_read(8'hAC, "R11");
        for (int k = 0; k < N*5; k++) apb_read(pick_addr(k), "R10");

        // Constrained random traffic
        for (int it = 0; it < 600; it++) begin
            automatic int k = int'($urandom_range(0, N*5 + 5));
            automatic logic [AW-1:0] a = pick_addr(k);
            if ($urandom_range(0, 2) == 0) begin
                automatic logic [31:0] d = $urandom();
                if (k < N*5 && k % 5 == 0) d = 32'($urandom_range(0, 12));
                if (k < N*5 && k % 5 == 2) d = 32'($urandom_range(0, 7));
                apb_write(a, d);
            end else begin
                apb_read(a, tag_of(a));
            end
            if ($urandom_range(0, 3) == 0) bus_idle(int'($urandom_range(0, 5)));
        end
        bus_idle(2);
        finish_run();
    end

endmodule